// File: doc/BRIEF.md
# Sigma-Delta Input Control with Settling Gate

This block is the digital control path in front of a sigma-delta converter's input multiplexer and programmable gain stage. Software writes the input pair and the gain code into a small register window. The block keeps these values in a shadow copy and passes them to the analog front end only when the decimation filter signals a step boundary. A value written in the middle of a conversion therefore never changes the front end partway through a filter step. A buffer speed code and an interrupt-delay code are kept in the same window. The buffer code goes straight to the front end.

The decimation filter needs a few results to settle after a start or after a change of input or gain. The block counts those results and withholds the conversion-complete interrupt until the count is used up. The number of results withheld is set by the interrupt-delay code. A level output shows whether results are currently trusted.

Top module: `sdm_input_ctrl`

## Requirements
- R1: After synchronous reset, `act_chan` is 0, `act_gain` is 0, `buf_mode` is 0 and `conv_irq` is 0. The settling count is zero, so `settled` is 1.
- R2: A write to address 0 stores the channel (data bits 2:0) and gain (data bits 5:3) in the shadow only. `act_chan` and `act_gain` take the shadow value on the clock edge where `dec_step` is high and are visible one cycle later. Without `dec_step` they stay unchanged.
- R3: When a write to address 0 and `dec_step` occur in the same cycle, the newly written channel and gain are the ones applied at that step.
- R4: Gain codes 6 and 7 are not valid. A write to address 0 that carries one of them leaves the stored gain unchanged but still stores the channel field.
- R5: A write to address 1 stores the buffer mode (data bits 1:0: 0 off, 1 low, 2 medium, 3 high speed) and the interrupt delay (data bits 3:2). `buf_mode` shows the new code one cycle after the write, without waiting for `dec_step`.
- R6: `conv_start` reloads the settling count to 3 minus the interrupt-delay code. Codes 0, 1, 2 and 3 withhold 3, 2, 1 and 0 results. A write to address 1 in the same cycle takes effect for that reload.
- R7: A `dec_step` that changes `act_chan` or `act_gain` reloads the settling count in the same way. A `dec_step` that changes neither leaves the count alone.
- R8: `conv_irq` is a one-cycle pulse in the cycle after a `result_rdy` that arrives while the count is zero. `settled` is high exactly while the count is zero.
- R9: Each `result_rdy` lowers a nonzero count by one, and the count stays at zero once there. A `result_rdy` in the same cycle as a reload raises no interrupt.
- R10: Writes to addresses 2 and 3 change no output and no stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 input select, 1 mode) |
| wr_data | input | 6 | Register write data |
| conv_start | input | 1 | Conversion start strobe |
| dec_step | input | 1 | Decimation-step boundary pulse from the filter |
| result_rdy | input | 1 | Filter result-ready pulse |
| act_chan | output | 3 | Input pair currently applied to the multiplexer |
| act_gain | output | 3 | Gain code currently applied to the gain stage |
| buf_mode | output | 2 | Input buffer speed code |
| conv_irq | output | 1 | Conversion-complete interrupt pulse |
| settled | output | 1 | High while results are trusted (settling count zero) |

## Verification
A wrong shadow register or a missed apply edge shows up on `act_chan` or `act_gain` one cycle after the `dec_step` that should have carried the value. It then stays wrong until the next step. A wrong settling count becomes visible on `settled` in the cycle after the reload or decrement. It reaches `conv_irq` only on the next `result_rdy`, so the stimulus issues results densely enough to reveal an off-by-one interrupt within a few results. The bench compares every output on every cycle with a model built from the requirements. Because of that, a divergence is caught on the first cycle it reaches a port.

// File: rtl/sdm_inctl_pkg.sv
package sdm_inctl_pkg;
  localparam int ADDR_SEL  = 0;
  localparam int ADDR_MODE = 1;

  typedef enum logic [1:0] {
    BUF_OFF  = 2'd0,
    BUF_LOW  = 2'd1,
    BUF_MED  = 2'd2,
    BUF_HIGH = 2'd3
  } buf_mode_e;
endpackage

// File: rtl/sdm_cfg_regs.sv
module sdm_cfg_regs
  import sdm_inctl_pkg::*;
#(
  parameter int CHAN_W    = 3,
  parameter int GAIN_W    = 3,
  parameter int NUM_GAINS = 6,
  parameter int DLY_W     = 2,
  parameter int BUF_W     = 2,
  parameter int ADDR_W    = 2,
  localparam int DATA_W   = CHAN_W + GAIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CHAN_W-1:0] chan_n,
  output logic [GAIN_W-1:0] gain_n,
  output logic [DLY_W-1:0]  dly_n,
  output logic [BUF_W-1:0]  buf_q
);
  localparam logic [GAIN_W:0] GAIN_LIM = (GAIN_W+1)'(NUM_GAINS);

  logic [CHAN_W-1:0] chan_q;
  logic [GAIN_W-1:0] gain_q;
  logic [DLY_W-1:0]  dly_q;
  logic [BUF_W-1:0]  buf_n;
  logic              sel_hit, mode_hit, gain_ok;
  logic [GAIN_W-1:0] wr_gain;

  assign sel_hit  = wr_en && (wr_addr == ADDR_W'(ADDR_SEL));
  assign mode_hit = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));
  assign wr_gain  = wr_data[CHAN_W +: GAIN_W];
  assign gain_ok  = ({1'b0, wr_gain} < GAIN_LIM);

  // Next-state values are also exported so a same-cycle write reaches the apply logic
  always_comb begin
    chan_n = chan_q;
    gain_n = gain_q;
    dly_n  = dly_q;
    buf_n  = buf_q;
    if (sel_hit) begin
      chan_n = wr_data[CHAN_W-1:0];
      if (gain_ok) gain_n = wr_gain;
    end
    if (mode_hit) begin
      buf_n = wr_data[BUF_W-1:0];
      dly_n = wr_data[BUF_W +: DLY_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      gain_q <= '0;
      dly_q  <= '0;
      buf_q  <= BUF_W'(BUF_OFF);
    end else begin
      chan_q <= chan_n;
      gain_q <= gain_n;
      dly_q  <= dly_n;
      buf_q  <= buf_n;
    end
  end

  // R4: stored gain never leaves the legal range
  p_shadow_gain_legal_r4: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, gain_q} < GAIN_LIM));

  // R10: a write outside the two decoded addresses leaves the shadow alone
  p_stray_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel_hit && !mode_hit) |=> ($stable(chan_q) && $stable(gain_q) && $stable(buf_q) && $stable(dly_q)));
endmodule

// File: rtl/sdm_apply_stage.sv
module sdm_apply_stage #(
  parameter int CHAN_W    = 3,
  parameter int GAIN_W    = 3,
  parameter int NUM_GAINS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_step,
  input  logic [CHAN_W-1:0] chan_n,
  input  logic [GAIN_W-1:0] gain_n,
  output logic [CHAN_W-1:0] act_chan,
  output logic [GAIN_W-1:0] act_gain,
  output logic              cfg_change
);
  localparam logic [GAIN_W:0] GAIN_LIM = (GAIN_W+1)'(NUM_GAINS);

  assign cfg_change = dec_step && ((chan_n != act_chan) || (gain_n != act_gain));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_chan <= '0;
      act_gain <= '0;
    end else if (dec_step) begin
      act_chan <= chan_n;
      act_gain <= gain_n;
    end
  end

  // R2: front-end values move only on a decimation step
  p_hold_between_steps_r2: assert property (@(posedge clk) disable iff (rst)
    !dec_step |=> ($stable(act_chan) && $stable(act_gain)));

  // R4: applied gain is always a legal code
  p_applied_gain_legal_r4: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, act_gain} < GAIN_LIM));
endmodule

// File: rtl/sdm_settle_gate.sv
module sdm_settle_gate #(
  parameter int DLY_W      = 2,
  parameter int SETTLE_MAX = 3,
  localparam int CNT_W     = (SETTLE_MAX < 1) ? 1 : $clog2(SETTLE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start,
  input  logic             cfg_change,
  input  logic             result_rdy,
  input  logic [DLY_W-1:0] dly_n,
  output logic             conv_irq,
  output logic             settled
);
  logic [CNT_W-1:0] cnt_q, cnt_n, reload_val;
  logic             reload, irq_n;

  assign reload     = conv_start || cfg_change;
  assign reload_val = (int'(dly_n) >= SETTLE_MAX) ? '0 : CNT_W'(SETTLE_MAX - int'(dly_n));
  assign irq_n      = result_rdy && (cnt_q == '0) && !reload;

  always_comb begin
    cnt_n = cnt_q;
    if (reload)                         cnt_n = reload_val;
    else if (result_rdy && cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      conv_irq <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      conv_irq <= irq_n;
    end
  end

  assign settled = (cnt_q == '0);

  // R9: count never exceeds the largest reload
  p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt_q) <= SETTLE_MAX));

  // R6: a start never produces an interrupt on the next cycle
  p_start_blocks_irq_r6: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_irq);

  // R8: an interrupt implies a result one cycle earlier and a settled filter
  p_irq_after_result_r8: assert property (@(posedge clk) disable iff (rst)
    conv_irq |-> ($past(result_rdy) && settled));
endmodule

// File: rtl/sdm_input_ctrl.sv
module sdm_input_ctrl #(
  parameter int CHAN_W     = 3,
  parameter int GAIN_W     = 3,
  parameter int NUM_GAINS  = 6,
  parameter int DLY_W      = 2,
  parameter int BUF_W      = 2,
  parameter int ADDR_W     = 2,
  parameter int SETTLE_MAX = 3,
  localparam int DATA_W    = CHAN_W + GAIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              conv_start,
  input  logic              dec_step,
  input  logic              result_rdy,
  output logic [CHAN_W-1:0] act_chan,
  output logic [GAIN_W-1:0] act_gain,
  output logic [BUF_W-1:0]  buf_mode,
  output logic              conv_irq,
  output logic              settled
);
  logic [CHAN_W-1:0] chan_n;
  logic [GAIN_W-1:0] gain_n;
  logic [DLY_W-1:0]  dly_n;
  logic              cfg_change;

  sdm_cfg_regs #(
    .CHAN_W(CHAN_W), .GAIN_W(GAIN_W), .NUM_GAINS(NUM_GAINS),
    .DLY_W(DLY_W), .BUF_W(BUF_W), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chan_n(chan_n), .gain_n(gain_n), .dly_n(dly_n), .buf_q(buf_mode)
  );

  sdm_apply_stage #(
    .CHAN_W(CHAN_W), .GAIN_W(GAIN_W), .NUM_GAINS(NUM_GAINS)
  ) apply_i (
    .clk(clk), .rst(rst), .dec_step(dec_step), .chan_n(chan_n), .gain_n(gain_n),
    .act_chan(act_chan), .act_gain(act_gain), .cfg_change(cfg_change)
  );

  sdm_settle_gate #(
    .DLY_W(DLY_W), .SETTLE_MAX(SETTLE_MAX)
  ) gate_i (
    .clk(clk), .rst(rst), .conv_start(conv_start), .cfg_change(cfg_change),
    .result_rdy(result_rdy), .dly_n(dly_n), .conv_irq(conv_irq), .settled(settled)
  );

  // R7: a step that changes the front end leaves the filter unsettled
  p_change_unsettles_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_step && (chan_n != act_chan)) |=> (!settled || !$stable(act_chan)));
endmodule

// File: tb/sdm_input_ctrl_tb.sv
module sdm_input_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, conv_start, dec_step, result_rdy;
  logic [1:0] wr_addr;
  logic [5:0] wr_data;
  logic [2:0] act_chan, act_gain;
  logic [1:0] buf_mode;
  logic       conv_irq, settled;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Model state from the requirements
  int m_chan_sh, m_gain_sh, m_buf, m_dly, m_chan, m_gain, m_cnt, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdm_input_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .conv_start(conv_start), .dec_step(dec_step), .result_rdy(result_rdy),
    .act_chan(act_chan), .act_gain(act_gain), .buf_mode(buf_mode),
    .conv_irq(conv_irq), .settled(settled)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int reload_of(input int dly);
    return (dly >= 3) ? 0 : 3 - dly;
  endfunction

  task automatic model_reset();
    m_chan_sh = 0; m_gain_sh = 0; m_buf = 0; m_dly = 0;
    m_chan = 0; m_gain = 0; m_cnt = 0; m_irq = 0;
  endtask

  // Advance the model across one rising edge for the inputs currently driven
  task automatic model_edge();
    int cn, gn, bn, dn, rl;
    bit chg, reload;
    cn = m_chan_sh; gn = m_gain_sh; bn = m_buf; dn = m_dly;
    if (wr_en && wr_addr == 2'd0) begin
      cn = int'(wr_data[2:0]);
      if (wr_data[5:3] < 3'd6) gn = int'(wr_data[5:3]);
    end
    if (wr_en && wr_addr == 2'd1) begin
      bn = int'(wr_data[1:0]);
      dn = int'(wr_data[3:2]);
    end
    chg    = dec_step && (cn != m_chan || gn != m_gain);
    reload = conv_start || chg;
    rl     = reload_of(dn);
    m_irq  = (result_rdy && m_cnt == 0 && !reload) ? 1 : 0;
    if (reload)                        m_cnt = rl;
    else if (result_rdy && m_cnt != 0) m_cnt = m_cnt - 1;
    if (dec_step) begin m_chan = cn; m_gain = gn; end
    m_chan_sh = cn; m_gain_sh = gn; m_buf = bn; m_dly = dn;
  endtask

  task automatic compare_all();
    chk("R2 act_chan", int'(act_chan), m_chan);
    chk("R2 act_gain", int'(act_gain), m_gain);
    chk("R5 buf_mode", int'(buf_mode), m_buf);
    chk("R8 conv_irq", int'(conv_irq), m_irq);
    chk("R8 settled",  int'(settled),  (m_cnt == 0) ? 1 : 0);
  endtask

  // Called at a falling edge: drive, advance model, check at next falling edge
  task automatic step(input bit w, input logic [1:0] a, input logic [5:0] d,
                      input bit s, input bit dc, input bit r);
    wr_en = w; wr_addr = a; wr_data = d;
    conv_start = s; dec_step = dc; result_rdy = r;
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 2'd0, 6'd0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7531));
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0;
    conv_start = 0; dec_step = 0; result_rdy = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 chan", int'(act_chan), 0);
    chk("R1 gain", int'(act_gain), 0);
    chk("R1 buf",  int'(buf_mode), 0);
    chk("R1 irq",  int'(conv_irq), 0);
    chk("R1 settled", int'(settled), 1);

    // R2: write is held until the decimation step
    step(1, 2'd0, {3'd2, 3'd5}, 0, 0, 0);
    chk("R2 held chan", int'(act_chan), 0);
    step(0, 2'd0, 6'd0, 0, 1, 0);
    chk("R2 applied chan", int'(act_chan), 5);
    chk("R2 applied gain", int'(act_gain), 2);
    chk("R7 change unsettles", int'(settled), 0);

    // R6/R8: three results withheld at delay code 0
    for (int i = 0; i < 3; i++) begin
      step(0, 2'd0, 6'd0, 0, 0, 1);
      chk("R6 withheld irq", int'(conv_irq), 0);
    end
    chk("R9 count at zero", int'(settled), 1);
    step(0, 2'd0, 6'd0, 0, 0, 1);
    chk("R8 irq pulse", int'(conv_irq), 1);
    idle();
    chk("R8 irq one cycle", int'(conv_irq), 0);

    // R3: same-cycle write and step
    step(1, 2'd0, {3'd1, 3'd7}, 0, 1, 0);
    chk("R3 chan", int'(act_chan), 7);
    chk("R3 gain", int'(act_gain), 1);

    // R4: illegal gain code keeps old gain, channel still taken
    step(1, 2'd0, {3'd6, 3'd3}, 0, 0, 0);
    step(0, 2'd0, 6'd0, 0, 1, 0);
    chk("R4 chan", int'(act_chan), 3);
    chk("R4 gain kept", int'(act_gain), 1);

    // R5: buffer mode immediate; delay code 3
    step(1, 2'd1, 6'b001110, 0, 0, 0);
    chk("R5 buf immediate", int'(buf_mode), 2);
    chk("R5 chan untouched", int'(act_chan), 3);
    step(0, 2'd0, 6'd0, 1, 0, 0);
    chk("R6 delay3 settled", int'(settled), 1);
    step(0, 2'd0, 6'd0, 0, 0, 1);
    chk("R6 delay3 irq", int'(conv_irq), 1);

    // R10: unused address
    step(1, 2'd2, 6'h3f, 0, 0, 0);
    step(1, 2'd3, 6'h3f, 0, 1, 0);
    chk("R10 chan", int'(act_chan), 3);
    chk("R10 gain", int'(act_gain), 1);
    chk("R10 buf", int'(buf_mode), 2);
    chk("R10 settled", int'(settled), 1);

    // R7: step without change does not reload (delay code 1)
    step(1, 2'd1, 6'b000110, 0, 0, 0);
    step(0, 2'd0, 6'd0, 0, 1, 0);
    chk("R7 no change keeps settled", int'(settled), 1);
    step(0, 2'd0, 6'd0, 1, 0, 0);
    chk("R6 delay1 reload", int'(settled), 0);

    // R9: reload and result together, then saturation
    step(0, 2'd0, 6'd0, 0, 0, 1);
    step(0, 2'd0, 6'd0, 1, 0, 1);
    chk("R9 no irq with reload", int'(conv_irq), 0);
    step(0, 2'd0, 6'd0, 0, 0, 1);
    step(0, 2'd0, 6'd0, 0, 0, 1);
    chk("R9 reached zero", int'(settled), 1);
    chk("R9 no irq yet", int'(conv_irq), 0);
    step(0, 2'd0, 6'd0, 0, 0, 1);
    step(0, 2'd0, 6'd0, 0, 0, 1);
    chk("R9 saturated irq", int'(conv_irq), 1);
    chk("R9 saturated settled", int'(settled), 1);

    // Constrained random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 10) < 3, 2'($urandom), 6'($urandom),
           ($urandom % 20) == 0, ($urandom % 5) == 0, ($urandom % 10) < 3);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule